// File: doc/BRIEF.md
# Dot-Matrix Display Host Register File

This block is the host-side storage of an eight-digit dot-matrix display controller. A host reaches it over an eight-bit data bus, split here into `din`, `dout` and an output enable `dout_oe`. Strobes are active low: chip select, write, read, flash select and reset. A five-bit address goes with them. Each access lands in one of five regions: an eight-cell character store, a one-bit-per-digit flash attribute store, a pointer to one of sixteen custom glyphs, the seven dot rows of the glyph that pointer selects, and a control byte.

The refresh logic sits outside this block. It reads the stores through independent combinational ports and takes the control byte from `ctrl_word`. A character cell holds an ASCII code when bit 7 is 0, or a glyph index in bits 3:0 when bit 7 is 1. The refresh logic interprets the cell; this block stores it unchanged.

The block also runs two multi-cycle housekeeping sequences: the clear command and the bus reset. `busy` is high while either one runs, and host writes are dropped during that time.

Top module: `dotmatrix_hostregs`

## Requirements
- R1: Region decode. `fsel_n`=0 selects the flash store whatever `addr[4:3]` holds. Otherwise `addr[4:3]` selects the region: 2'b00 is the glyph pointer, 2'b01 is a glyph row, 2'b10 is the control byte and 2'b11 is the character store. `addr[2:0]` is the digit, or the row.
- R2: An access performs exactly one write: at the first rising clock edge where `cs_n` and `wr_n` are both low. Data that changes later in the same low period of `cs_n` is not stored. A new write needs `cs_n` to go high first.
- R3: A character cell stores all eight bits. Digit 0 is the leftmost. The value reads back on the bus and on `ref_char` for `ref_digit`.
- R4: The glyph pointer keeps `din[3:0]`. On read, bits 7:4 return 0.
- R5: A glyph row write stores `din[4:0]` into row `addr[2:0]` of the glyph the pointer selects. Bit 4 is the leftmost column. Row 3'b111 does not exist: a write to it is ignored and a read of it returns 0. Bits 7:5 read back as 0. `ref_dots` returns row `ref_row` of glyph `ref_glyph`.
- R6: A flash write stores `din[0]` for the addressed digit. A read returns the stored bit in bit 0 and zeros elsewhere. `ref_flash` gives the bit for `ref_digit`.
- R7: A control write replaces bits 7:6 and 4:0 together. Bit 5 cannot be written: it always shows the `st_pass` input, both on read-back and on `ctrl_word`.
- R8: A control write with bit 7 = 1 starts a clear. `busy` rises after that edge and stays high for 3 cycles. At the end, every character cell holds 8'h20 and every flash bit is 1. Bit 7 returns to 0, while the other control bits, the glyph pointer and the glyph rows stay unchanged.
- R9: While `rst_n` is low, every character cell becomes 8'h20 and the flash store and control byte become 0; the glyph rows and pointer are kept. `busy` is high during reset and for 3 cycles after its release.
- R10: Host writes to any region are ignored while `busy` is high.
- R11: `dout_oe` is high only while `cs_n` and `rd_n` are both low. Otherwise `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base of the busy sequences |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| fsel_n | input | 1 | Flash-store select, active low |
| addr | input | 5 | Region bits [4:3], digit or row [2:0] |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| dout_oe | output | 1 | High while the block drives the bus |
| st_pass | input | 1 | Self-test result, shown as control bit 5 |
| busy | output | 1 | Clear or reset sequence in progress |
| ctrl_word | output | 8 | Control byte for the refresh logic |
| ref_digit | input | 3 | Refresh digit select |
| ref_char | output | 8 | Character cell at `ref_digit` |
| ref_flash | output | 1 | Flash bit at `ref_digit` |
| ref_glyph | input | 4 | Refresh glyph select |
| ref_row | input | 3 | Refresh row select |
| ref_dots | output | 5 | Dots of the selected glyph row |

## Verification
The checker tests four things on every cycle:
- reset is followed by `busy` and blank character cells;
- the control byte holds still while a post-reset busy window runs;
- a pending clear bit never appears without `busy`;
- the bus output stays off and zero unless chip select and read are both low.

The following can only be shown by the bench scenarios:
- the per-region storage and read-back of every cell, pointer and glyph row, including the missing eighth row;
- the one-write-per-select rule when data changes mid-access;
- the fill values after clear and after reset;
- a glyph pointer write during a clear being discarded.

// File: rtl/disp_regs_pkg.sv
`timescale 1ns/1ps
// Shared constants and the region type for the display host register file.
// Assumes an eight-digit display with sixteen custom glyphs of seven rows.
package disp_regs_pkg;
    localparam int DIGITS      = 8;
    localparam int DIGIT_AW    = $clog2(DIGITS);
    localparam int GLYPHS      = 16;
    localparam int GLYPH_AW    = $clog2(GLYPHS);
    localparam int GLYPH_ROWS  = 7;
    localparam int ROW_AW      = 3;
    localparam int DOT_W       = 5;
    localparam int BUSY_CYCLES = 3;
    localparam logic [7:0] BLANK_CODE = 8'h20;

    typedef enum logic [2:0] {
        RG_FLASH = 3'd0,
        RG_PTR   = 3'd1,
        RG_ROW   = 3'd2,
        RG_CTRL  = 3'd3,
        RG_CHAR  = 3'd4
    } region_e;
endpackage

// File: rtl/dr_bus_decode.sv
`timescale 1ns/1ps
// Host bus decoder: maps flash select and address bits to a region and
// produces a single write strobe per chip-select low period.
// Assumes the host returns cs_n high between successive accesses.
module dr_bus_decode
    import disp_regs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      wr_n,
    input  logic      fsel_n,
    input  logic [1:0] region_bits,
    output region_e   region,
    output logic      wr_stb
);
    logic taken_q;

    // Region select: flash select overrides the region bits.
    always_comb begin
        if (!fsel_n) begin
            region = RG_FLASH;
        end else begin
            case (region_bits)
                2'b00:   region = RG_PTR;
                2'b01:   region = RG_ROW;
                2'b10:   region = RG_CTRL;
                default: region = RG_CHAR;
            endcase
        end
    end

    // Remember that this select period has already written.
    always_ff @(posedge clk) begin
        if (!rst_n)     taken_q <= 1'b0;
        else if (cs_n)  taken_q <= 1'b0;
        else if (!wr_n) taken_q <= 1'b1;
    end

    assign wr_stb = !cs_n && !wr_n && !taken_q;
endmodule

// File: rtl/dr_busy_seq.sv
`timescale 1ns/1ps
// Busy sequencer: holds busy during reset and for CYCLES clocks after
// reset release or after a start pulse; flags the final busy cycle.
module dr_busy_seq #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);
    logic [CW-1:0] cnt_q;

    // Load on reset or start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= LOAD;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/dr_char_store.sv
`timescale 1ns/1ps
// Character cells and per-digit flash bits, with reset and clear fills.
// One host port (read/write) and one refresh read port.
module dr_char_store
    import disp_regs_pkg::*;
#(
    parameter int N  = DIGITS,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic          we_char,
    input  logic          we_flash,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    input  logic          wflash,
    input  logic [AW-1:0] ref_idx,
    output logic [7:0]    rd_char,
    output logic          rd_flash,
    output logic [7:0]    ref_char,
    output logic          ref_flash
);
    logic [7:0] cell_q [N];
    logic [N-1:0] flash_q;

    // Per-cell storage: reset blanks, clear blanks, else host write.
    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q[g]  <= BLANK_CODE;
                flash_q[g] <= 1'b0;
            end else if (fill) begin
                cell_q[g]  <= BLANK_CODE;
                flash_q[g] <= 1'b1;
            end else begin
                if (we_char && idx == AW'(g))  cell_q[g]  <= wdata;
                if (we_flash && idx == AW'(g)) flash_q[g] <= wflash;
            end
        end
    end

    assign rd_char   = cell_q[idx];
    assign rd_flash  = flash_q[idx];
    assign ref_char  = cell_q[ref_idx];
    assign ref_flash = flash_q[ref_idx];
endmodule

// File: rtl/dr_glyph_store.sv
`timescale 1ns/1ps
// Custom glyph dot rows. Not reset: contents survive bus reset and clear.
// Row addresses at or beyond ROWS are not stored and read as zero.
module dr_glyph_store
    import disp_regs_pkg::*;
#(
    parameter int NG   = GLYPHS,
    parameter int ROWS = GLYPH_ROWS,
    parameter int GAW  = $clog2(NG),
    parameter int RAW  = ROW_AW,
    parameter int W    = DOT_W
) (
    input  logic           clk,
    input  logic           we,
    input  logic [GAW-1:0] glyph,
    input  logic [RAW-1:0] row,
    input  logic [W-1:0]   wdots,
    input  logic [GAW-1:0] ref_glyph,
    input  logic [RAW-1:0] ref_row,
    output logic [W-1:0]   rd_dots,
    output logic [W-1:0]   ref_dots
);
    localparam int SLOTS = 1 << RAW;
    logic [W-1:0] mem_q [NG][SLOTS];

    // Host write into an existing row only.
    always_ff @(posedge clk) begin
        if (we && int'(row) < ROWS) mem_q[glyph][row] <= wdots;
    end

    assign rd_dots  = (int'(row) < ROWS)     ? mem_q[glyph][row]         : '0;
    assign ref_dots = (int'(ref_row) < ROWS) ? mem_q[ref_glyph][ref_row] : '0;
endmodule

// File: rtl/dotmatrix_hostregs.sv
`timescale 1ns/1ps
// Host register file of an eight-digit dot-matrix display controller.
// Decodes host accesses, holds the control byte and glyph pointer, runs
// the clear and reset busy windows, and muxes read data onto the bus.
// Assumes clk is the refresh time base and cs_n toggles between accesses.
module dotmatrix_hostregs
    import disp_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                fsel_n,
    input  logic [4:0]          addr,
    input  logic [7:0]          din,
    output logic [7:0]          dout,
    output logic                dout_oe,
    input  logic                st_pass,
    output logic                busy,
    output logic [7:0]          ctrl_word,
    input  logic [DIGIT_AW-1:0] ref_digit,
    output logic [7:0]          ref_char,
    output logic                ref_flash,
    input  logic [GLYPH_AW-1:0] ref_glyph,
    input  logic [ROW_AW-1:0]   ref_row,
    output logic [DOT_W-1:0]    ref_dots
);
    region_e             region;
    logic                wr_stb, wr_ok, seq_last, clr_start, fill;
    logic [1:0]          ctrl_hi_q;
    logic [4:0]          ctrl_lo_q;
    logic [GLYPH_AW-1:0] ptr_q;
    logic [7:0]          rd_char;
    logic                rd_flash;
    logic [DOT_W-1:0]    rd_dots;

    dr_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .fsel_n(fsel_n),
        .region_bits(addr[4:3]), .region(region), .wr_stb(wr_stb)
    );

    assign wr_ok     = wr_stb && !busy;
    assign clr_start = wr_ok && region == RG_CTRL && din[7];
    assign fill      = busy && ctrl_hi_q[1];

    dr_busy_seq #(.CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(clr_start),
        .busy(busy), .last(seq_last)
    );

    dr_char_store #(.N(DIGITS)) u_chars (
        .clk(clk), .rst_n(rst_n), .fill(fill),
        .we_char(wr_ok && region == RG_CHAR),
        .we_flash(wr_ok && region == RG_FLASH),
        .idx(addr[DIGIT_AW-1:0]), .wdata(din), .wflash(din[0]),
        .ref_idx(ref_digit), .rd_char(rd_char), .rd_flash(rd_flash),
        .ref_char(ref_char), .ref_flash(ref_flash)
    );

    dr_glyph_store u_glyphs (
        .clk(clk), .we(wr_ok && region == RG_ROW), .glyph(ptr_q),
        .row(addr[ROW_AW-1:0]), .wdots(din[DOT_W-1:0]),
        .ref_glyph(ref_glyph), .ref_row(ref_row),
        .rd_dots(rd_dots), .ref_dots(ref_dots)
    );

    // Control byte: reset to zero, full update on write, clear bit self-resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_hi_q <= '0;
            ctrl_lo_q <= '0;
        end else if (wr_ok && region == RG_CTRL) begin
            ctrl_hi_q <= din[7:6];
            ctrl_lo_q <= din[4:0];
        end else if (seq_last) begin
            ctrl_hi_q[1] <= 1'b0;
        end
    end

    // Glyph pointer: not reset, written from the low data bits.
    always_ff @(posedge clk) begin
        if (wr_ok && region == RG_PTR) ptr_q <= din[GLYPH_AW-1:0];
    end

    assign ctrl_word = {ctrl_hi_q, st_pass, ctrl_lo_q};
    assign dout_oe   = !cs_n && !rd_n;

    // Read mux: region data zero-extended, zero when not driving.
    always_comb begin
        dout = '0;
        if (dout_oe) begin
            case (region)
                RG_FLASH: dout = {7'b0, rd_flash};
                RG_PTR:   dout = 8'(ptr_q);
                RG_ROW:   dout = 8'(rd_dots);
                RG_CTRL:  dout = ctrl_word;
                default:  dout = rd_char;
            endcase
        end
    end
endmodule

// File: rtl/dotmatrix_hostregs_chk.sv
`timescale 1ns/1ps
// Property checker for the display host register file, bound to the top.
module dotmatrix_hostregs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic       busy,
    input logic [7:0] ctrl_word,
    input logic [7:0] ref_char
);
    // R9: reset is followed by a busy window.
    assert_reset_busy_R9: assert property (@(posedge clk) !rst_n |=> busy);

    // R9: cells are blank on the cycle after a reset edge.
    assert_reset_blank_R9: assert property (@(posedge clk) !rst_n |=> (ref_char == 8'h20));

    // R10: outside a clear, the control byte cannot change while busy.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctrl_word[7]) |=> ((ctrl_word & 8'hDF) == ($past(ctrl_word) & 8'hDF)));

    // R8: a pending clear bit is always accompanied by busy.
    assert_clear_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[7] |-> busy);

    // R11: bus stays released and zero unless select and read are low.
    assert_bus_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!dout_oe && dout == 8'h00));
endmodule

bind dotmatrix_hostregs dotmatrix_hostregs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .dout(dout),
    .dout_oe(dout_oe), .busy(busy), .ctrl_word(ctrl_word), .ref_char(ref_char)
);

// File: tb/dotmatrix_hostregs_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every cell, flash bit, glyph and row, then
// exercises write-once, clear, reset and busy write blocking.
module dotmatrix_hostregs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fsel_n = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic       st_pass = 1'b0;
    logic       busy;
    logic [7:0] ctrl_word;
    logic [2:0] ref_digit = '0;
    logic [7:0] ref_char;
    logic       ref_flash;
    logic [3:0] ref_glyph = '0;
    logic [2:0] ref_row = '0;
    logic [4:0] ref_dots;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dotmatrix_hostregs u_dotmatrix_hostregs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .fsel_n(fsel_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .st_pass(st_pass), .busy(busy), .ctrl_word(ctrl_word),
        .ref_digit(ref_digit), .ref_char(ref_char), .ref_flash(ref_flash),
        .ref_glyph(ref_glyph), .ref_row(ref_row), .ref_dots(ref_dots)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic fs_n, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; fsel_n = fs_n; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; fsel_n = 1'b1;
    endtask

    task automatic bus_read(input logic fs_n, input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; fsel_n = fs_n; addr = a;
        #1;
        d = dout;
        cs_n = 1'b1; rd_n = 1'b1; fsel_n = 1'b1;
    endtask

    function automatic logic [7:0] cell_pat(input int i);
        return (i % 2 == 1) ? 8'(8'h80 | (i * 2)) : 8'(8'h30 + i * 5);
    endfunction

    function automatic logic [4:0] dot_pat(input int k, input int r);
        return 5'((k * 5 + r * 3 + 1) & 31);
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        // R9: reset state and busy window
        repeat (3) @(negedge clk);
        check("R9 busy in reset", {7'b0, busy}, 8'h01);
        rst_n = 1'b1;
        check("R9 busy after release", {7'b0, busy}, 8'h01);
        for (int i = 0; i < 8; i++) begin
            ref_digit = 3'(i); #0.1;
            check("R9 reset cell blank", ref_char, 8'h20);
            check("R9 reset flash zero", {7'b0, ref_flash}, 8'h00);
        end
        check("R9 reset ctrl zero", ctrl_word, 8'h00);
        @(negedge clk); @(negedge clk);
        check("R9 busy third cycle", {7'b0, busy}, 8'h01);
        @(negedge clk);
        check("R9 busy ends", {7'b0, busy}, 8'h00);

        // R11: bus released when not reading
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R11 oe with cs high", {7'b0, dout_oe}, 8'h00);
        check("R11 dout zero cs high", dout, 8'h00);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R11 oe with rd high", {7'b0, dout_oe}, 8'h00);
        cs_n = 1'b1;

        // R3: character cells
        for (int i = 0; i < 8; i++) bus_write(1'b1, 5'(8'h18 | i), cell_pat(i));
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b1, 5'(8'h18 | i), rd);
            check("R3 cell read", rd, cell_pat(i));
            ref_digit = 3'(i); #0.1;
            check("R3 cell ref", ref_char, cell_pat(i));
        end

        // R6: flash bits, upper data bits ignored
        for (int i = 0; i < 8; i++) bus_write(1'b0, 5'(i), 8'(8'hA6 | (i % 3 == 0 ? 1 : 0)));
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b0, 5'(i), rd);
            check("R6 flash read", rd, (i % 3 == 0) ? 8'h01 : 8'h00);
            ref_digit = 3'(i); #0.1;
            check("R6 flash ref", {7'b0, ref_flash}, (i % 3 == 0) ? 8'h01 : 8'h00);
        end

        // R4 R5: glyph pointer and rows, full sweep
        for (int k = 0; k < 16; k++) begin
            bus_write(1'b1, 5'h00, 8'(8'hF0 | k));
            bus_read(1'b1, 5'h00, rd);
            check("R4 pointer read", rd, 8'(k));
            for (int r = 0; r < 7; r++) bus_write(1'b1, 5'(8'h08 | r), 8'(8'hE0 | dot_pat(k, r)));
            bus_write(1'b1, 5'h0F, 8'h1F);
            for (int r = 0; r < 8; r++) begin
                bus_read(1'b1, 5'(8'h08 | r), rd);
                check("R5 row read", rd, (r < 7) ? 8'(dot_pat(k, r)) : 8'h00);
            end
        end
        for (int k = 0; k < 16; k++)
            for (int r = 0; r < 8; r++) begin
                ref_glyph = 4'(k); ref_row = 3'(r); #0.1;
                check("R5 row ref", 8'(ref_dots), (r < 7) ? 8'(dot_pat(k, r)) : 8'h00);
            end

        // R1: flash select overrides region bits; pointer untouched
        bus_write(1'b1, 5'h00, 8'h05);
        bus_write(1'b0, 5'h02, 8'h01);
        bus_read(1'b1, 5'h00, rd);
        check("R1 pointer untouched by flash", rd, 8'h05);
        bus_read(1'b0, 5'h1A, rd);
        check("R1 flash via region bits 11", rd, 8'h01);
        bus_read(1'b1, 5'h1A, rd);
        check("R1 char region", rd, cell_pat(2));

        // R7: control byte, bit 5 follows st_pass
        st_pass = 1'b1;
        bus_write(1'b1, 5'h10, 8'h5B);
        bus_read(1'b1, 5'h10, rd);
        check("R7 ctrl read pass", rd, 8'h7B);
        st_pass = 1'b0; #0.1;
        check("R7 ctrl word fail", ctrl_word, 8'h5B);
        bus_write(1'b1, 5'h13, 8'h3F);
        bus_read(1'b1, 5'h10, rd);
        check("R7 bit5 not writable", rd, 8'h1F);

        // R2: one write per select period
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 5'h1C; din = 8'h55;
        @(negedge clk); din = 8'h66;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        bus_read(1'b1, 5'h1C, rd);
        check("R2 first data kept", rd, 8'h55);
        bus_write(1'b1, 5'h1C, 8'h66);
        bus_read(1'b1, 5'h1C, rd);
        check("R2 next select writes", rd, 8'h66);

        // R8 R10: clear, with pointer write during busy
        bus_write(1'b1, 5'h10, 8'h9A);
        check("R8 busy after clear", {7'b0, busy}, 8'h01);
        check("R8 clear bit visible", {7'b0, ctrl_word[7]}, 8'h01);
        bus_write(1'b1, 5'h00, 8'h03);
        @(negedge clk);
        check("R8 busy ended", {7'b0, busy}, 8'h00);
        check("R8 ctrl after clear", ctrl_word, 8'h1A);
        for (int i = 0; i < 8; i++) begin
            bus_read(1'b1, 5'(8'h18 | i), rd);
            check("R8 cell blank", rd, 8'h20);
            bus_read(1'b0, 5'(i), rd);
            check("R8 flash set", rd, 8'h01);
        end
        bus_read(1'b1, 5'h00, rd);
        check("R10 pointer write ignored", rd, 8'h05);
        bus_read(1'b1, 5'h0A, rd);
        check("R8 glyph row kept", rd, 8'(dot_pat(5, 2)));

        // R9 R10: second reset keeps glyphs, write during busy dropped
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_write(1'b1, 5'h10, 8'h11);
        repeat (2) @(negedge clk);
        check("R10 ctrl write during reset busy", ctrl_word, 8'h00);
        bus_read(1'b0, 5'h03, rd);
        check("R9 flash cleared", rd, 8'h00);
        bus_read(1'b1, 5'h1C, rd);
        check("R9 cell blank", rd, 8'h20);
        bus_read(1'b1, 5'h00, rd);
        check("R9 pointer kept", rd, 8'h05);
        bus_read(1'b1, 5'h0D, rd);
        check("R9 glyph kept", rd, 8'(dot_pat(5, 5)));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule